// File: doc/BRIEF.md
# ADC Conversion Start and Tracking Controller

This block is the digital sequencer in front of a successive-approximation converter. Software programs an 8-bit control register that enables the converter, chooses the tracking style and selects the event that starts a conversion. The block then drives a track strobe and a convert strobe for the analog side, shows a busy flag while a conversion runs, and latches a completion flag that software must clear.

Five start sources are supported: a software write of the busy bit, two timer overflow pulses, the rising edge of an external convert-start pin (after a two-flip-flop synchronizer), and a software start issued to a companion converter. In continuous tracking the converter tracks whenever it is not converting. In low-power tracking the trigger opens a tracking window of a fixed number of SAR clocks, and the conversion follows it. The exception is the external pin, whose low level gates tracking directly and whose rising edge starts the conversion. The SAR clock is the system clock divided by a parameter. Its phase restarts with every accepted trigger, so windows and conversions last an exact number of system cycles.

The sequencer has four states. OFF is held while the converter is disabled. READY waits for a trigger. WINDOW is the timed low-power tracking phase. CONVERT is the conversion itself. The transitions are:
- enable (OFF to READY);
- trigger in continuous mode or pin mode (READY to CONVERT);
- trigger in timed mode (READY to WINDOW);
- window expiry (WINDOW to CONVERT);
- conversion done (CONVERT to READY);
- disable, from any state (to OFF).

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset the register reads 0x00. Its layout is: bit 7 enable, bit 6 tracking style (1 = low-power), bit 5 completion flag, bit 4 busy, bits 3:1 start-mode field. Bit 0 reads 0 whatever is written to it.
- R2: While enable is 0, track and convert stay low and no start source, including a busy-bit write, starts a conversion.
- R3: With enable 1 and tracking style 0, track is high in every cycle except while convert is high.
- R4: The start-mode field selects the only source that can start a conversion: 000 = busy-bit write, 001 = timer-3 pulse, 010 = rising edge of the pin, 011 = timer-2 pulse, 1xx = companion start pulse. All other sources are ignored.
- R5: With tracking style 1 and a field other than 010, an accepted trigger raises track for exactly TRACK_CLKS SAR clocks (TRACK_CLKS × SAR_DIV cycles), and convert follows at once.
- R6: With tracking style 1 and field 010, track equals the inverted synchronized pin level while idle, and the synchronized rising edge starts the conversion.
- R7: Busy and convert are high for exactly CONV_CLKS SAR clocks (CONV_CLKS × SAR_DIV cycles), and track is low during that time. Writing busy = 1 starts a conversion only when the field is written as 000 and was already 000. Writing 0 to busy has no effect.
- R8: The completion flag (also on irq_o) is set in the same cycle that busy falls at the end of a conversion. It stays set until software writes 0 to bit 5. Writing 1 to bit 5 never sets it.
- R9: A trigger that arrives while a window or a conversion is running is dropped. No conversion follows it.
- R10: Writing enable = 0 during a conversion drops busy and convert on the next cycle, and the completion flag is not set.
- R11: The SAR clock is the system clock divided by SAR_DIV, and its phase restarts at each accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tmr3_ovf | input | 1 | Timer-3 overflow pulse |
| tmr2_ovf | input | 1 | Timer-2 overflow pulse |
| ext_cnv_in | input | 1 | Asynchronous external convert-start pin |
| peer_sw_start | input | 1 | Software start pulse of the companion converter |
| track_o | output | 1 | Track (sample) strobe |
| convert_o | output | 1 | Conversion-enable strobe |
| irq_o | output | 1 | Completion flag |

## Verification
A sequencer stuck in the wrong state shows at the ports at once. If it is stuck in WINDOW or CONVERT, track or convert stays high past its exact cycle budget. If it misses READY, the next trigger starts nothing. A tick counter that is off by one changes the measured window or conversion length by SAR_DIV cycles, and that is seen when busy falls. A wrong start-mode decode shows within a few cycles, because a non-selected pulse raises convert or a selected one fails to.

// File: rtl/adc_start_pkg.sv
`timescale 1ns/1ps
package adc_start_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_READY,
        ST_WINDOW,
        ST_CONVERT
    } seq_state_t;

    localparam int BIT_EN   = 7;
    localparam int BIT_TM   = 6;
    localparam int BIT_FLAG = 5;
    localparam int BIT_BUSY = 4;
    localparam int MODE_LSB = 1;

    localparam logic [2:0] MODE_SW  = 3'b000;
    localparam logic [2:0] MODE_T3  = 3'b001;
    localparam logic [2:0] MODE_PIN = 3'b010;
    localparam logic [2:0] MODE_T2  = 3'b011;
endpackage

// File: rtl/adc_sar_tick.sv
`timescale 1ns/1ps
module adc_sar_tick #(
    parameter int SAR_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (SAR_DIV > 1) ? $clog2(SAR_DIV) : 1;

    generate
        if (SAR_DIV == 1) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || cnt == CW'(SAR_DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = run && (cnt == CW'(SAR_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/adc_pin_sync.sv
`timescale 1ns/1ps
module adc_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic meta, stage, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta  <= 1'b0;
            stage <= 1'b0;
            prev  <= 1'b0;
        end else begin
            meta  <= pin;
            stage <= meta;
            prev  <= stage;
        end
    end

    assign level = stage;
    assign rise  = stage && !prev;
endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_start_pkg::*;
#(
    parameter int TRACK_CLKS = 3,
    parameter int CONV_CLKS  = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       trig,
    input  logic       timed,
    input  logic       tick,
    output seq_state_t state,
    output logic       done
);
    localparam int MAXC = (TRACK_CLKS > CONV_CLKS) ? TRACK_CLKS : CONV_CLKS;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t      nxt;
    logic [CW-1:0]   cnt;
    logic            win_end, conv_end;

    assign win_end  = tick && (cnt == CW'(TRACK_CLKS - 1));
    assign conv_end = tick && (cnt == CW'(CONV_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:     nxt = ST_READY;
                ST_READY:   if (trig) nxt = timed ? ST_WINDOW : ST_CONVERT;
                ST_WINDOW:  if (win_end) nxt = ST_CONVERT;
                ST_CONVERT: if (conv_end) nxt = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (nxt != state) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = en && (state == ST_CONVERT) && conv_end;
endmodule

// File: rtl/adc_start_ctrl.sv
`timescale 1ns/1ps
module adc_start_ctrl
    import adc_start_pkg::*;
#(
    parameter int SAR_DIV    = 2,
    parameter int TRACK_CLKS = 3,
    parameter int CONV_CLKS  = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tmr3_ovf,
    input  logic       tmr2_ovf,
    input  logic       ext_cnv_in,
    input  logic       peer_sw_start,
    output logic       track_o,
    output logic       convert_o,
    output logic       irq_o
);
    logic       en_q, tm_q, flag_q;
    logic [2:0] mode_q;
    logic       en_next, sw_go, trig, timed, tick, done, run;
    logic       pin_level, pin_rise;
    logic       unused_bit0;
    seq_state_t state;

    assign unused_bit0 = reg_wdata[0];

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            tm_q   <= 1'b0;
            mode_q <= MODE_SW;
        end else if (reg_wr) begin
            en_q   <= reg_wdata[BIT_EN];
            tm_q   <= reg_wdata[BIT_TM];
            mode_q <= reg_wdata[MODE_LSB +: 3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (reg_wr && !reg_wdata[BIT_FLAG]) begin
            flag_q <= 1'b0;
        end
    end

    assign en_next = reg_wr ? reg_wdata[BIT_EN] : en_q;
    assign sw_go   = reg_wr && reg_wdata[BIT_BUSY] && (reg_wdata[MODE_LSB +: 3] == MODE_SW);
    assign timed   = tm_q && (mode_q != MODE_PIN);

    // start-source selection
    always_comb begin
        unique casez (mode_q)
            MODE_SW:  trig = sw_go;
            MODE_T3:  trig = tmr3_ovf;
            MODE_PIN: trig = pin_rise;
            MODE_T2:  trig = tmr2_ovf;
            default:  trig = peer_sw_start;
        endcase
    end

    adc_pin_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_cnv_in),
        .level (pin_level),
        .rise  (pin_rise)
    );

    assign run = (state == ST_WINDOW) || (state == ST_CONVERT);

    adc_sar_tick #(.SAR_DIV(SAR_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_seq_fsm #(.TRACK_CLKS(TRACK_CLKS), .CONV_CLKS(CONV_CLKS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_next),
        .trig  (trig),
        .timed (timed),
        .tick  (tick),
        .state (state),
        .done  (done)
    );

    // outputs per state
    always_comb begin
        track_o   = 1'b0;
        convert_o = 1'b0;
        unique case (state)
            ST_OFF:     ;
            ST_READY:   track_o = en_q && (!tm_q || (mode_q == MODE_PIN && !pin_level));
            ST_WINDOW:  track_o = en_q;
            ST_CONVERT: convert_o = en_q;
        endcase
    end

    assign irq_o     = flag_q;
    assign reg_rdata = {en_q, tm_q, flag_q, convert_o, mode_q, 1'b0};
endmodule

// File: rtl/adc_start_ctrl_chk.sv
`timescale 1ns/1ps
module adc_start_ctrl_chk #(
    parameter int CONV_CYCLES = 28
) (
    input logic clk,
    input logic rst_n,
    input logic reg_wr,
    input logic wr_flag,
    input logic en_bit,
    input logic tm_bit,
    input logic busy_bit,
    input logic track_o,
    input logic convert_o,
    input logic irq_o
);
    logic [15:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (convert_o) begin
            busy_run <= busy_run + 1'b1;
        end else begin
            busy_run <= '0;
        end
    end

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bit |-> (!track_o && !convert_o));

    a_r3_continuous_track: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bit && !tm_bit && !convert_o) |-> track_o);

    a_r7_no_track_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        convert_o |-> !track_o);

    a_r7_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(convert_o) && en_bit) |-> (busy_run == 16'(CONV_CYCLES)));

    a_r8_flag_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $fell(busy_bit));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(reg_wr) && !$past(wr_flag)));

    a_r10_abort_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(convert_o) && !en_bit) |-> !$rose(irq_o));
endmodule

bind adc_start_ctrl adc_start_ctrl_chk #(.CONV_CYCLES(CONV_CLKS * SAR_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .wr_flag   (reg_wdata[5]),
    .en_bit    (reg_rdata[7]),
    .tm_bit    (reg_rdata[6]),
    .busy_bit  (reg_rdata[4]),
    .track_o   (track_o),
    .convert_o (convert_o),
    .irq_o     (irq_o)
);

// File: tb/adc_start_ctrl_test.sv
`timescale 1ns/1ps
module adc_start_ctrl_test;
    localparam int DIV  = 2;
    localparam int TRK  = 3;
    localparam int CONV = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tmr3_ovf = 1'b0, tmr2_ovf = 1'b0, ext_cnv_in = 1'b0, peer_sw_start = 1'b0;
    logic       track_o, convert_o, irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    adc_start_ctrl #(.SAR_DIV(DIV), .TRACK_CLKS(TRK), .CONV_CLKS(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr3_ovf(tmr3_ovf), .tmr2_ovf(tmr2_ovf),
        .ext_cnv_in(ext_cnv_in), .peer_sw_start(peer_sw_start),
        .track_o(track_o), .convert_o(convert_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input int which);
        @(negedge clk);
        if (which == 0) tmr3_ovf = 1'b1;
        if (which == 1) tmr2_ovf = 1'b1;
        if (which == 2) peer_sw_start = 1'b1;
        @(negedge clk);
        tmr3_ovf = 1'b0;
        tmr2_ovf = 1'b0;
        peer_sw_start = 1'b0;
    endtask

    task automatic run_case(input int tm, input int mode);
        logic [7:0] cfg;
        int win, cnt, bad_trk, g;
        cfg = {1'b1, tm[0], 2'b00, mode[2:0], 1'b0};
        wr(cfg);
        idle(4);
        // R3 / R6: idle tracking
        check($sformatf("R3 R6 idle track tm=%0d mode=%0d", tm, mode), track_o, (tm == 0 || mode == 2) ? 1 : 0);
        check("R7 idle busy bit", reg_rdata[4], 0);
        // R4: decoys from non-selected sources
        if (mode != 1) pulse_src(0);
        if (mode != 3) pulse_src(1);
        if (mode < 4) pulse_src(2);
        if (mode != 0) wr(cfg | 8'h10);
        if (mode != 2) begin
            ext_cnv_in = 1'b1;
            idle(4);
            ext_cnv_in = 1'b0;
        end
        idle(4);
        check($sformatf("R4 decoys ignored mode=%0d", mode), convert_o, 0);
        check("R4 decoys keep track", track_o, (tm == 0 || mode == 2) ? 1 : 0);
        // fire the selected source
        @(negedge clk);
        case (mode)
            0: begin reg_wr = 1'b1; reg_wdata = cfg | 8'h10; end
            1: tmr3_ovf = 1'b1;
            2: ext_cnv_in = 1'b1;
            3: tmr2_ovf = 1'b1;
            default: peer_sw_start = 1'b1;
        endcase
        @(negedge clk);
        reg_wr = 1'b0;
        tmr3_ovf = 1'b0;
        tmr2_ovf = 1'b0;
        peer_sw_start = 1'b0;
        win = 0;
        g = 0;
        while (!convert_o && g < 100) begin
            if (track_o) win++;
            @(negedge clk);
            g++;
        end
        if (tm == 1 && mode != 2)
            check($sformatf("R5 R11 window length mode=%0d", mode), win, TRK * DIV);
        cnt = 0;
        bad_trk = 0;
        g = 0;
        while (convert_o && g < 1000) begin
            cnt++;
            g++;
            if (track_o) bad_trk++;
            // R9: retriggers during the conversion
            if (cnt == 2) begin
                tmr3_ovf = 1'b1; tmr2_ovf = 1'b1; peer_sw_start = 1'b1;
                if (mode == 2) ext_cnv_in = 1'b0;
            end
            if (cnt == 3) begin
                tmr3_ovf = 1'b0; tmr2_ovf = 1'b0; peer_sw_start = 1'b0;
            end
            if (cnt == 4 && mode == 0) begin reg_wr = 1'b1; reg_wdata = cfg | 8'h10; end
            if (cnt == 5) reg_wr = 1'b0;
            if (cnt == 6 && mode == 2) ext_cnv_in = 1'b1;
            @(negedge clk);
        end
        check($sformatf("R7 R11 conversion length tm=%0d mode=%0d", tm, mode), cnt, CONV * DIV);
        check("R7 track low while converting", bad_trk, 0);
        check("R8 flag set at completion", reg_rdata[5], 1);
        check("R8 irq_o at completion", irq_o, 1);
        check("R3 R5 R6 track after completion", track_o, (tm == 0) ? 1 : 0);
        idle(30);
        check($sformatf("R9 nothing queued mode=%0d", mode), convert_o, 0);
        wr(cfg | 8'h20);
        check("R8 flag held when writing 1", irq_o, 1);
        wr(cfg);
        check("R8 flag cleared by writing 0", irq_o, 0);
        wr(cfg | 8'h20);
        check("R8 writing 1 does not set flag", irq_o, 0);
        ext_cnv_in = 1'b0;
        idle(4);
    endtask

    initial begin
        #2000000;
        if (!done_flag) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state and layout
        check("R1 reset register", reg_rdata, 8'h00);
        check("R1 reset track", track_o, 0);
        check("R1 reset convert", convert_o, 0);
        // R2 disabled: no start from any source
        wr(8'h10);
        idle(3);
        check("R2 busy write while disabled", convert_o, 0);
        pulse_src(0);
        pulse_src(1);
        pulse_src(2);
        idle(3);
        check("R2 disabled convert", convert_o, 0);
        check("R2 disabled track", track_o, 0);
        wr(8'h01);
        check("R1 bit0 reads zero", reg_rdata, 8'h00);
        wr(8'hFF);
        check("R1 layout after 0xFF write", reg_rdata, 8'hCE);
        wr(8'h00);
        // R4 R5 R6 R7 R8 R9 sweep
        for (int tm = 0; tm < 2; tm++) begin
            for (int mode = 0; mode < 8; mode++) begin
                run_case(tm, mode);
            end
        end
        // R10 abort
        wr(8'h80);
        wr(8'h90);
        idle(5);
        check("R10 conversion running", convert_o, 1);
        wr(8'h00);
        check("R10 abort drops convert", convert_o, 0);
        check("R10 abort drops busy bit", reg_rdata[4], 0);
        idle(40);
        check("R10 no flag after abort", irq_o, 0);
        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule